// File: doc/BRIEF.md
# Four-Mode Timer/Counter Pair

This block holds two up-counting timer/counter channels. Each one counts either internal machine ticks, produced once every twelve clock cycles, or rising edges on its own external event input. A two-bit mode field per channel sets how the channel's low and high count bytes are joined. The choices are a 13-bit counter with a 5-bit low prescaler, a 16-bit counter, an 8-bit counter that reloads itself from the high byte, and a split mode. In split mode channel 0 becomes two separate 8-bit counters and channel 1 holds its count.

Software sets the mode word and preloads the count bytes through a simple register write port, and it can read every register back. A channel counts only while its run input is high. When a channel overflows it sets a sticky flag, and that flag is the channel's interrupt request. The flag is cleared by writing a one to its bit in the flag register or by pulsing the channel's acknowledge input. To get a period of N ticks in 16-bit mode, preload the count with 65536 minus N.

Top module: `mcu_timer_pair`

## Requirements
- R1: After a synchronous reset, the mode word, all four count bytes and both flags are zero, and every register reads back as zero.
- R2: Register map. Address 0 is the mode word: channel i's mode is in bits 4i+1..4i and its source select is in bit 4i+2. Addresses 1 and 2 are channel 0's low and high bytes. Addresses 3 and 4 are channel 1's low and high bytes. Address 5 holds the flags in bits 1..0. A write is visible on the read port one cycle later and overrides any count in that same cycle.
- R3: With source select 0, a running channel advances exactly once every 12 clock cycles.
- R4: A channel whose run input is low holds its count bytes, and its flag does not change.
- R5: Mode 00 (13-bit): bits 4..0 of the low byte count and carry into the high byte. Low-byte bits 7..5 are not changed by counting. The flag sets when all 13 bits roll over to zero.
- R6: Mode 01 (16-bit): high and low bytes form one counter. The flag sets on the wrap from 0xFFFF to 0x0000, so a preload of 65536-N overflows on the N-th tick.
- R7: Mode 10 (auto-reload): the low byte counts. On its overflow the low byte is loaded from the high byte and the flag sets, so overflows repeat every 256-high ticks.
- R8: Mode 11 on channel 0: the low byte counts on channel 0's source gated by run bit 0 and sets flag 0. The high byte counts machine ticks gated by run bit 1 and sets flag 1.
- R9: Mode 11 on channel 1 holds channel 1's count bytes even while run bit 1 is high.
- R10: While channel 0 is in mode 11, overflows of channel 1 do not set flag 1, but channel 1 still counts under run bit 1.
- R11: With source select 1, a channel counts rising edges of its external event input after a two-flop synchronizer, and machine ticks have no effect on it.
- R12: Writing address 5 with bit i set clears flag i, and a zero bit leaves the flag unchanged. A high acknowledge input i clears flag i. An overflow in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| run | input | 2 | Per-channel run enables |
| ext_evt | input | 2 | Per-channel external event inputs |
| int_ack | input | 2 | Per-channel flag acknowledge |
| ovf_flag | output | 2 | Per-channel overflow flag / interrupt request |

## Verification
The hardest situation to reach is split mode. There the two run inputs are crossed: run bit 1 drives the upper half of channel 0, and flag 1 stops following channel 1. The bench preloads both halves of channel 0 close to overflow and preloads channel 1 with values it can recognise. It then raises each run bit alone. This shows that each half sets only its own flag and that channel 1 stays frozen. In a second setup, channel 1 is left in 16-bit mode and made to wrap while channel 0 is split, and flag 1 must stay clear. The auto-reload period is checked as an exact cycle count between two overflows, with a flag acknowledge placed between them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    parameter int BYTE_W   = 8;
    parameter int ADDR_W   = 3;
    parameter int NCH      = 2;
    parameter int TICK_DIV = 12;
    parameter int PRE_BITS = 5;

    typedef enum logic [1:0] {
        MODE_13    = 2'b00,
        MODE_16    = 2'b01,
        MODE_8AR   = 2'b10,
        MODE_SPLIT = 2'b11
    } tmr_mode_e;

    // Per-channel slice of the mode word: bit 2 source, bits 1..0 mode
    typedef struct packed {
        logic      ext_src;
        tmr_mode_e mode;
    } ch_cfg_t;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_FLAG = 3'd5;

    function automatic ch_cfg_t cfg_slice(input logic [BYTE_W-1:0] ctrl, input int ch);
        return ch_cfg_t'(ctrl[4*ch +: 3]);
    endfunction

    function automatic logic [ADDR_W-1:0] lo_addr(input int ch);
        return ADDR_W'(1 + 2 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] hi_addr(input int ch);
        return ADDR_W'(2 + 2 * ch);
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int DIV  = 12,
    parameter int NEXT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NEXT-1:0] ext_in,
    output logic            mach_tick,
    output logic [NEXT-1:0] ext_tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst)                div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    assign mach_tick = (div_q == LAST);

    for (genvar g = 0; g < NEXT; g++) begin : g_sync
        logic meta_q, sync_q, prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= ext_in[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end
        assign ext_tick[g] = sync_q & ~prev_q;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W        = 8,
    parameter int PB       = 5,
    parameter bit SPLIT_OK = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  tmr_mode_e mode,
    input  logic      en_lo,
    input  logic      en_hi,
    input  logic      wr_lo,
    input  logic      wr_hi,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_lo,
    output logic [W-1:0] cnt_hi,
    output logic      ovf_lo,
    output logic      ovf_hi
);
    localparam logic [W-1:0]   ONES    = '1;
    localparam logic [PB-1:0]  PRE_MAX = '1;

    logic [W-1:0] lo_q, hi_q, lo_d, hi_d;

    always_comb begin
        lo_d   = lo_q;
        hi_d   = hi_q;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        case (mode)
            MODE_13: if (en_lo) begin
                if (lo_q[PB-1:0] == PRE_MAX) begin
                    lo_d[PB-1:0] = '0;
                    hi_d         = hi_q + 1'b1;
                    ovf_lo       = (hi_q == ONES);
                end else begin
                    lo_d[PB-1:0] = lo_q[PB-1:0] + 1'b1;
                end
            end
            MODE_16: if (en_lo) begin
                {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
                ovf_lo       = (hi_q == ONES) && (lo_q == ONES);
            end
            MODE_8AR: if (en_lo) begin
                if (lo_q == ONES) begin
                    lo_d   = hi_q;
                    ovf_lo = 1'b1;
                end else begin
                    lo_d = lo_q + 1'b1;
                end
            end
            MODE_SPLIT: if (SPLIT_OK) begin
                if (en_lo) begin
                    lo_d   = lo_q + 1'b1;
                    ovf_lo = (lo_q == ONES);
                end
                if (en_hi) begin
                    hi_d   = hi_q + 1'b1;
                    ovf_hi = (hi_q == ONES);
                end
            end
            default: ;
        endcase
        if (wr_lo) lo_d = wr_data;
        if (wr_hi) hi_d = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign cnt_lo = lo_q;
    assign cnt_hi = hi_q;
endmodule

// File: rtl/mcu_timer_pair.sv
module mcu_timer_pair
    import tmr_pkg::*;
#(
    parameter int TICK_DIV_P = tmr_pkg::TICK_DIV,
    parameter int PRE_BITS_P = tmr_pkg::PRE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [NCH-1:0]    run,
    input  logic [NCH-1:0]    ext_evt,
    input  logic [NCH-1:0]    int_ack,
    output logic [NCH-1:0]    ovf_flag
);
    logic [BYTE_W-1:0]            ctrl_q;
    ch_cfg_t                      cfg [NCH];
    logic                         mach_tick;
    logic [NCH-1:0]               ext_tick;
    logic [NCH-1:0]               en_lo, en_hi, wr_lo, wr_hi, ovf_lo, ovf_hi;
    logic [NCH-1:0][BYTE_W-1:0]   cnt_lo, cnt_hi;
    logic [NCH-1:0]               flag_set, flag_clr;
    logic [NCH-1:0]               flag_q;
    logic                         ch0_split;
    tmr_mode_e                    ch0_mode;

    always_ff @(posedge clk) begin
        if (rst)                                   ctrl_q <= '0;
        else if (wr_en && wr_addr == ADR_CTRL)     ctrl_q <= wr_data;
    end

    tmr_tick_gen #(.DIV(TICK_DIV_P), .NEXT(NCH)) tick_i (
        .clk      (clk),
        .rst      (rst),
        .ext_in   (ext_evt),
        .mach_tick(mach_tick),
        .ext_tick (ext_tick)
    );

    assign ch0_mode  = cfg[0].mode;
    assign ch0_split = (ch0_mode == MODE_SPLIT);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign cfg[g]   = cfg_slice(ctrl_q, g);
        assign en_lo[g] = run[g] & (cfg[g].ext_src ? ext_tick[g] : mach_tick);
        assign wr_lo[g] = wr_en && (wr_addr == lo_addr(g));
        assign wr_hi[g] = wr_en && (wr_addr == hi_addr(g));

        if (g == 0) begin : g_split_hi
            // Upper half of channel 0 borrows run bit 1 when split
            assign en_hi[g] = ch0_split ? (run[1] & mach_tick) : en_lo[g];
        end else begin : g_plain_hi
            assign en_hi[g] = en_lo[g];
        end

        tmr_channel #(.W(BYTE_W), .PB(PRE_BITS_P), .SPLIT_OK(g == 0)) ch_i (
            .clk    (clk),
            .rst    (rst),
            .mode   (cfg[g].mode),
            .en_lo  (en_lo[g]),
            .en_hi  (en_hi[g]),
            .wr_lo  (wr_lo[g]),
            .wr_hi  (wr_hi[g]),
            .wr_data(wr_data),
            .cnt_lo (cnt_lo[g]),
            .cnt_hi (cnt_hi[g]),
            .ovf_lo (ovf_lo[g]),
            .ovf_hi (ovf_hi[g])
        );

        assign flag_clr[g] = int_ack[g] | (wr_en && (wr_addr == ADR_FLAG) && wr_data[g]);

        always_ff @(posedge clk) begin
            if (rst)               flag_q[g] <= 1'b0;
            else if (flag_set[g])  flag_q[g] <= 1'b1;
            else if (flag_clr[g])  flag_q[g] <= 1'b0;
        end
    end

    assign flag_set[0] = ovf_lo[0];
    assign flag_set[1] = ch0_split ? ovf_hi[0] : (ovf_lo[1] | ovf_hi[1]);
    assign ovf_flag    = flag_q;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CTRL:   rd_data = ctrl_q;
            lo_addr(0): rd_data = cnt_lo[0];
            hi_addr(0): rd_data = cnt_hi[0];
            lo_addr(1): rd_data = cnt_lo[1];
            hi_addr(1): rd_data = cnt_hi[1];
            ADR_FLAG:   rd_data = BYTE_W'(flag_q);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mcu_timer_pair_chk.sv
module mcu_timer_pair_chk #(
    parameter int DIV = 12
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] run,
    input logic       wr_en,
    input logic [1:0] int_ack,
    input logic [1:0] ovf_flag,
    input logic [1:0] flag_set,
    input logic       mach_tick,
    input logic [7:0] lo0,
    input logic [7:0] hi0,
    input logic [1:0] mode0
);
    int unsigned gap_q;

    always_ff @(posedge clk) begin
        if (rst || mach_tick) gap_q <= 0;
        else                  gap_q <= gap_q + 1;
    end

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        mach_tick |-> gap_q == DIV - 1);

    assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (rst)
        (!run[0] && !run[1] && !wr_en) |=> ($stable(lo0) && $stable(hi0)));

    assert_flag0_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag[0]) |-> $past(run[0]));

    assert_flag1_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag[1]) |-> $past(run[1]));

    assert_wrap16_R6: assert property (@(posedge clk) disable iff (rst)
        (mode0 == 2'b01 && flag_set[0] && !wr_en) |=> (lo0 == 8'h00 && hi0 == 8'h00));

    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (mode0 == 2'b10 && flag_set[0] && !wr_en) |=> lo0 == $past(hi0));

    assert_ack_clears_R12: assert property (@(posedge clk) disable iff (rst)
        (int_ack[0] && !flag_set[0]) |=> !ovf_flag[0]);

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
        flag_set[1] |=> ovf_flag[1]);
endmodule

bind mcu_timer_pair mcu_timer_pair_chk #(.DIV(TICK_DIV_P)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .wr_en    (wr_en),
    .int_ack  (int_ack),
    .ovf_flag (ovf_flag),
    .flag_set (flag_set),
    .mach_tick(mach_tick),
    .lo0      (cnt_lo[0]),
    .hi0      (cnt_hi[0]),
    .mode0    (ch0_mode)
);

// File: tb/mcu_timer_pair_tb.sv
module mcu_timer_pair_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;
    logic [1:0] run;
    logic [1:0] ext_evt;
    logic [1:0] int_ack;
    logic [1:0] ovf_flag;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    mcu_timer_pair dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .run(run), .ext_evt(ext_evt),
        .int_ack(int_ack), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        n_total++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_flag(input int idx, output int n);
        n = 0;
        while (!ovf_flag[idx] && n < 4000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            check("R1 reset read", d, 0);
        end
        check("R1 reset flags", ovf_flag, 0);
    endtask

    task automatic t_regmap;
        logic [7:0] d;
        wr(3'd0, 8'h21); rd(3'd0, d); check("R2 mode word", d, 8'h21);
        wr(3'd1, 8'hA5); rd(3'd1, d); check("R2 ch0 low", d, 8'hA5);
        wr(3'd4, 8'h3C); rd(3'd4, d); check("R2 ch1 high", d, 8'h3C);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd4, 8'h00);
    endtask

    task automatic t_tick_rate;
        logic [7:0] d, prev;
        int n;
        wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        run = 2'b01;
        rd(3'd1, prev);
        n = 0;
        do begin @(negedge clk); rd(3'd1, d); n++; end while (d == prev && n < 100);
        for (int k = 0; k < 2; k++) begin
            prev = d; n = 0;
            do begin @(negedge clk); rd(3'd1, d); n++; end while (d == prev && n < 100);
            check("R3 tick spacing", n, 12);
        end
        run = 2'b00;
    endtask

    task automatic t_mode16;
        logic [7:0] d;
        int n;
        wr(3'd0, 8'h01); wr(3'd1, 8'hFB); wr(3'd2, 8'hFF);
        run = 2'b01;
        wait_flag(0, n);
        run = 2'b00;
        check_range("R6 16-bit period", n, 49, 60);
        rd(3'd1, d); check("R6 wrap low", d, 0);
        rd(3'd2, d); check("R6 wrap high", d, 0);
    endtask

    task automatic t_stopped;
        logic [7:0] a0, b0, a1, b1;
        wr(3'd1, 8'h37);
        rd(3'd1, a0); rd(3'd2, b0);
        repeat (100) @(negedge clk);
        rd(3'd1, a1); rd(3'd2, b1);
        check("R4 low held", a1, a0);
        check("R4 high held", b1, b0);
        check("R4 flag held", ovf_flag[0], 1);
    endtask

    task automatic t_flag_clear;
        wr(3'd5, 8'h00);
        check("R12 zero write keeps flag", ovf_flag[0], 1);
        wr(3'd5, 8'h01);
        check("R12 one write clears flag", ovf_flag[0], 0);
    endtask

    task automatic t_mode13;
        logic [7:0] d;
        int n;
        wr(3'd0, 8'h00); wr(3'd1, 8'hFC); wr(3'd2, 8'hFF);
        run = 2'b01;
        wait_flag(0, n);
        run = 2'b00;
        check_range("R5 13-bit period", n, 37, 48);
        rd(3'd1, d); check("R5 low upper bits kept", d, 8'hE0);
        rd(3'd2, d); check("R5 high wrapped", d, 0);
        wr(3'd5, 8'h03);
    endtask

    task automatic t_reload;
        logic [7:0] d;
        int n;
        wr(3'd0, 8'h02); wr(3'd2, 8'hF0); wr(3'd1, 8'hFD);
        run = 2'b01;
        wait_flag(0, n);
        check_range("R7 first overflow", n, 25, 36);
        rd(3'd1, d); check("R7 reloaded low", d, 8'hF0);
        int_ack = 2'b01;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                int_ack = 2'b00;
                check("R12 ack clears flag", ovf_flag[0], 0);
            end
        end while (!ovf_flag[0] && n < 400);
        run = 2'b00;
        check("R7 reload period", n, 192);
        wr(3'd5, 8'h03);
    endtask

    task automatic t_split;
        logic [7:0] d;
        int n;
        wr(3'd0, 8'h33);
        wr(3'd1, 8'hFE); wr(3'd2, 8'hFD); wr(3'd3, 8'h44); wr(3'd4, 8'h55);
        run = 2'b01;
        wait_flag(0, n);
        run = 2'b00;
        check_range("R8 low half period", n, 13, 24);
        check("R8 high half flag idle", ovf_flag[1], 0);
        rd(3'd2, d); check("R8 high half idle", d, 8'hFD);
        wr(3'd5, 8'h01);
        run = 2'b10;
        wait_flag(1, n);
        run = 2'b00;
        check_range("R8 high half period", n, 25, 36);
        check("R8 low half flag idle", ovf_flag[0], 0);
        rd(3'd3, d); check("R9 ch1 low frozen", d, 8'h44);
        rd(3'd4, d); check("R9 ch1 high frozen", d, 8'h55);
        wr(3'd5, 8'h03);
    endtask

    task automatic t_split_steal;
        logic [7:0] d;
        wr(3'd0, 8'h13);
        wr(3'd3, 8'hFE); wr(3'd4, 8'hFF); wr(3'd2, 8'h00);
        run = 2'b10;
        repeat (84) @(negedge clk);
        run = 2'b00;
        rd(3'd4, d); check("R10 ch1 still wrapped", d, 0);
        check("R10 flag1 not set by ch1", ovf_flag[1], 0);
        wr(3'd5, 8'h03);
    endtask

    task automatic t_external;
        logic [7:0] d;
        wr(3'd0, 8'h50); wr(3'd3, 8'h10); wr(3'd4, 8'h00);
        run = 2'b10;
        repeat (100) @(negedge clk);
        rd(3'd3, d); check("R11 no machine counting", d, 8'h10);
        for (int p = 0; p < 5; p++) begin
            ext_evt[1] = 1'b1; repeat (4) @(negedge clk);
            ext_evt[1] = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd(3'd3, d); check("R11 external edges", d, 8'h15);
        run = 2'b00;
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        run = '0; ext_evt = '0; int_ack = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_tick_rate();
        t_mode16();
        t_stopped();
        t_flag_clear();
        t_mode13();
        t_reload();
        t_split();
        t_split_steal();
        t_external();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule